// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the 32-bit multiply and divide engine that sits beside an integer pipeline. It owns two result registers, HI and LO, and changes them only in response to a command. A command is an operation code plus two 32-bit operands, presented with a one-cycle `start` strobe. Multiplies split the 64-bit product across HI (upper word) and LO (lower word). Divides place the quotient in LO and the remainder in HI. Two move commands load one of the pair directly from the first operand. The block returns no direct result, so HI and LO are the only way to see what a command did.

Multiplication completes in a single datapath cycle. Division uses a restoring shift-subtract loop on magnitudes, one quotient bit per clock, followed by a sign fix-up cycle. A controller built around four named states sequences the work. **IDLE** waits for a command. **MUL** writes the product. **DIV** runs the 32 division steps. **FIX** applies the signs and writes the result. The transitions are:
- IDLE→MUL when a multiply is accepted.
- IDLE→DIV when a divide is accepted.
- IDLE→IDLE when a move is accepted or when no command is accepted.
- MUL→IDLE after one cycle.
- DIV→DIV until the last step, then DIV→FIX.
- FIX→IDLE after one cycle.

`busy` is high while the controller is outside IDLE. `done` pulses for one cycle when HI/LO have just been written.

Top module: `muldiv_unit`

## Requirements
- R1: After reset `hi`, `lo`, `busy` and `done` are all zero.
- R2: `op`=0 (signed multiply) sign-extends both operands and writes product bits 63:32 to `hi` and bits 31:0 to `lo`.
- R3: `op`=1 (unsigned multiply) forms the 64-bit unsigned product and splits it between `hi` and `lo` the same way as R2.
- R4: `op`=2 (signed divide) writes the quotient, truncated toward zero, to `lo` and the remainder, carrying the dividend's sign, to `hi`.
- R5: `op`=3 (unsigned divide) writes the unsigned quotient to `lo` and the unsigned remainder to `hi`.
- R6: A divide by zero, signed or unsigned, finishes with the normal divide latency, with `lo` = 0xFFFFFFFF and `hi` equal to the dividend.
- R7: Signed divide of 0x80000000 by 0xFFFFFFFF gives `lo` = 0x80000000 and `hi` = 0.
- R8: `op`=4 copies `opa` into `hi` and leaves `lo` unchanged. `op`=5 copies `opa` into `lo` and leaves `hi` unchanged.
- R9: Number the accepting clock edge 0. `done` is seen high after edge 0 for a move, after edge 1 for a multiply, and after edge 33 for a divide. `done` is high for exactly one cycle. `busy` is high from the accepting edge until the edge that raises `done`, and is low while `done` is high. `hi`/`lo` change only on the edge that raises `done`.
- R10: A `start` while `busy` is high is ignored. The running command finishes with its own result and latency, and no second command follows.
- R11: `op` codes 6 and 7 are ignored. They raise neither `busy` nor `done` and leave `hi` and `lo` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, sampled when idle |
| op | input | 3 | Operation code (0..5 valid) |
| opa | input | 32 | First operand: dividend, multiplicand or move source |
| opb | input | 32 | Second operand: divisor or multiplier |
| busy | output | 1 | Multi-cycle command in progress |
| done | output | 1 | One-cycle pulse when HI/LO were written |
| hi | output | 32 | HI register |
| lo | output | 32 | LO register |

## Verification
The assertions assume that reset is asserted before the first edge and that `opb` matters only on the accepting edge. This holds because the divider captures the divisor magnitude internally and never reads the port again. The remainder bound assumes a nonzero captured divisor, so the stimulus runs divide-by-zero cases as well to exercise the path where that bound is switched off. The stimulus changes inputs only on falling edges and lowers `start` after one cycle. The only exception is the deliberate collision, in which `start` is pulsed while `busy` is high. No stimulus ever asserts reset in the middle of a command.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    localparam logic [2:0] OP_MULS = 3'd0;
    localparam logic [2:0] OP_MULU = 3'd1;
    localparam logic [2:0] OP_DIVS = 3'd2;
    localparam logic [2:0] OP_DIVU = 3'd3;
    localparam logic [2:0] OP_MTHI = 3'd4;
    localparam logic [2:0] OP_MTLO = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_DIV  = 2'd2,
        ST_FIX  = 2'd3
    } md_state_e;

endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
    parameter int W = 32
) (
    input  logic           is_signed,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [PW-1:0] a_ext;
    logic [PW-1:0] b_ext;

    always_comb begin
        a_ext = {{W{is_signed & a[W-1]}}, a};
        b_ext = {{W{is_signed & b[W-1]}}, b};
        // Low 2W bits of the extended product equal the two's-complement product.
        prod  = a_ext * b_ext;
    end
endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         is_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quo_out,
    output logic [W-1:0] rem_out
);
    logic [W-1:0] rem_q;
    logic [W-1:0] quo_q;
    logic [W-1:0] dvs_q;
    logic         neg_quo_q;
    logic         neg_rem_q;

    logic         a_neg;
    logic         b_neg;
    logic [W-1:0] a_mag;
    logic [W-1:0] b_mag;
    logic [W:0]   shifted;
    logic [W:0]   diff;

    always_comb begin
        a_neg   = is_signed & dividend[W-1];
        b_neg   = is_signed & divisor[W-1];
        a_mag   = a_neg ? (~dividend + 1'b1) : dividend;
        b_mag   = b_neg ? (~divisor + 1'b1) : divisor;
        shifted = {rem_q, quo_q[W-1]};
        diff    = shifted - {1'b0, dvs_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q     <= '0;
            quo_q     <= '0;
            dvs_q     <= '0;
            neg_quo_q <= 1'b0;
            neg_rem_q <= 1'b0;
        end else if (load) begin
            rem_q     <= '0;
            quo_q     <= a_mag;
            dvs_q     <= b_mag;
            // A zero divisor keeps the all-ones quotient unnegated.
            neg_quo_q <= (a_neg ^ b_neg) & (|divisor);
            neg_rem_q <= a_neg;
        end else if (step) begin
            if (!diff[W]) begin
                rem_q <= diff[W-1:0];
                quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
                rem_q <= shifted[W-1:0];
                quo_q <= {quo_q[W-2:0], 1'b0};
            end
        end
    end

    always_comb begin
        quo_out = neg_quo_q ? (~quo_q + 1'b1) : quo_q;
        rem_out = neg_rem_q ? (~rem_q + 1'b1) : rem_q;
    end

    // R5: a restoring step leaves the partial remainder below a nonzero divisor
    a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && (|dvs_q)) |=> (rem_q < dvs_q));

endmodule

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] op,
    output logic       accept,
    output logic       div_load,
    output logic       div_step,
    output logic       mv_hi,
    output logic       mv_lo,
    output logic       wr_mul,
    output logic       wr_div,
    output logic       busy,
    output logic       done
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    md_state_e     state_q;
    md_state_e     state_n;
    logic [CW-1:0] cnt_q;
    logic          op_valid;
    logic          op_mul;
    logic          op_div;

    always_comb begin
        op_valid = (op <= OP_MTLO);
        op_mul   = (op == OP_MULS) || (op == OP_MULU);
        op_div   = (op == OP_DIVS) || (op == OP_DIVU);
        accept   = start && (state_q == ST_IDLE) && op_valid;
        div_load = accept && op_div;
        mv_hi    = accept && (op == OP_MTHI);
        mv_lo    = accept && (op == OP_MTLO);
        div_step = (state_q == ST_DIV);
        wr_mul   = (state_q == ST_MUL);
        wr_div   = (state_q == ST_FIX);
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && op_mul)      state_n = ST_MUL;
                else if (accept && op_div) state_n = ST_DIV;
            end
            ST_MUL:  state_n = ST_IDLE;
            ST_DIV:  if (cnt_q == LAST) state_n = ST_FIX;
            ST_FIX:  state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            if (accept)                 cnt_q <= '0;
            else if (state_q == ST_DIV) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            busy <= (state_n != ST_IDLE);
            done <= mv_hi || mv_lo || wr_mul || wr_div;
        end
    end

    // R9: busy only ever drops on the edge that raises done
    a_r9_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10: nothing is accepted while a command is running
    a_r10_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept);

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [2:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    localparam int PW = 2 * W;

    logic          accept;
    logic          div_load;
    logic          div_step;
    logic          mv_hi;
    logic          mv_lo;
    logic          wr_mul;
    logic          wr_div;
    logic [W-1:0]  mul_a_q;
    logic [W-1:0]  mul_b_q;
    logic          mul_sgn_q;
    logic [PW-1:0] prod;
    logic [W-1:0]  quo;
    logic [W-1:0]  rem;

    muldiv_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op       (op),
        .accept   (accept),
        .div_load (div_load),
        .div_step (div_step),
        .mv_hi    (mv_hi),
        .mv_lo    (mv_lo),
        .wr_mul   (wr_mul),
        .wr_div   (wr_div),
        .busy     (busy),
        .done     (done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mul_a_q   <= '0;
            mul_b_q   <= '0;
            mul_sgn_q <= 1'b0;
        end else if (accept) begin
            mul_a_q   <= opa;
            mul_b_q   <= opb;
            mul_sgn_q <= (op == OP_MULS);
        end
    end

    muldiv_mul #(.W(W)) u_mul (
        .is_signed (mul_sgn_q),
        .a         (mul_a_q),
        .b         (mul_b_q),
        .prod      (prod)
    );

    muldiv_div #(.W(W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (div_load),
        .step      (div_step),
        .is_signed (op == OP_DIVS),
        .dividend  (opa),
        .divisor   (opb),
        .quo_out   (quo),
        .rem_out   (rem)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi <= '0;
            lo <= '0;
        end else begin
            if (mv_hi) hi <= opa;
            if (mv_lo) lo <= opa;
            if (wr_mul) begin
                hi <= prod[PW-1:W];
                lo <= prod[W-1:0];
            end
            if (wr_div) begin
                hi <= rem;
                lo <= quo;
            end
        end
    end

    // R9: done and busy are never high together
    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: HI/LO hold while busy unless the result lands with done
    a_r9_hilo_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (done || ($stable(hi) && $stable(lo))));

    // R8: move-to-HI keeps LO
    a_r8_mthi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
        mv_hi |=> $stable(lo));

    // R8: move-to-LO keeps HI
    a_r8_mtlo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        mv_lo |=> $stable(hi));

endmodule

// File: tb/muldiv_unit_test.sv
`timescale 1ns/1ps
module muldiv_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        busy;
    logic        done;
    logic [31:0] hi;
    logic [31:0] lo;

    int checks = 0;
    int failures = 0;
    logic [31:0] m_hi = '0;
    logic [31:0] m_lo = '0;

    always #10 clk = ~clk;

    muldiv_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opa(opa), .opb(opb), .busy(busy), .done(done), .hi(hi), .lo(lo)
    );

    localparam int NV = 12;
    localparam logic [66:0] VEC [0:NV-1] = '{
        {3'd0, 32'h00000007, 32'hFFFFFFFD},
        {3'd0, 32'h80000000, 32'h80000000},
        {3'd0, 32'hFFFFFFFF, 32'hFFFFFFFF},
        {3'd1, 32'hFFFFFFFF, 32'hFFFFFFFF},
        {3'd1, 32'h12345678, 32'h9ABCDEF0},
        {3'd2, 32'h00000007, 32'h00000002},
        {3'd2, 32'hFFFFFFF9, 32'h00000002},
        {3'd2, 32'h00000007, 32'hFFFFFFFE},
        {3'd3, 32'hFFFFFFFF, 32'h00000010},
        {3'd3, 32'h00000005, 32'h00000009},
        {3'd4, 32'hDEADBEEF, 32'h00000000},
        {3'd5, 32'h0BADF00D, 32'h00000000}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] o);
        case (o)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            default: return "R8";
        endcase
    endfunction

    function automatic int lat_of(input logic [2:0] o);
        if (o <= 3'd1) return 1;
        if (o <= 3'd3) return 33;
        return 0;
    endfunction

    // Reference model written from the requirements, 64-bit arithmetic
    task automatic model(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, q, r;
        logic [63:0] p;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (o)
            3'd0: begin p = 64'(sa * sb); m_hi = p[63:32]; m_lo = p[31:0]; end
            3'd1: begin p = {32'd0, a} * {32'd0, b}; m_hi = p[63:32]; m_lo = p[31:0]; end
            3'd2: begin
                if (b == 0) begin m_lo = 32'hFFFFFFFF; m_hi = a; end
                else begin q = sa / sb; r = sa % sb; m_lo = q[31:0]; m_hi = r[31:0]; end
            end
            3'd3: begin
                if (b == 0) begin m_lo = 32'hFFFFFFFF; m_hi = a; end
                else begin m_lo = a / b; m_hi = a % b; end
            end
            3'd4: m_hi = a;
            3'd5: m_lo = a;
            default: ;
        endcase
    endtask

    task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b, output int lat);
        @(negedge clk);
        start = 1'b1; op = o; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        #(20ns * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(hi == 0 && lo == 0 && !busy && !done, "R1", {hi, lo}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [2:0]  vo;
            logic [31:0] va, vb;
            vo = VEC[i][66:64]; va = VEC[i][63:32]; vb = VEC[i][31:0];
            model(vo, va, vb);
            run_op(vo, va, vb, lat);
            check({hi, lo} == {m_hi, m_lo}, req_of(vo), {hi, lo}, {m_hi, m_lo});
            check(lat == lat_of(vo), "R9", 64'(lat), 64'(lat_of(vo)));
            @(negedge clk);
            check(!done, "R9 pulse", {63'd0, done}, 64'd0);
        end

        // R9: busy during a divide
        @(negedge clk);
        start = 1'b1; op = 3'd3; opa = 32'd50; opb = 32'd7;
        @(negedge clk);
        start = 1'b0;
        check(busy && !done, "R9 busy", {62'd0, busy, done}, 64'd2);
        repeat (10) @(negedge clk);
        check(busy, "R9 busy", {63'd0, busy}, 64'd1);
        while (!done) @(negedge clk);
        check(!busy, "R9 busy low with done", {63'd0, busy}, 64'd0);
        @(negedge clk);

        // R6: divide by zero, signed then unsigned
        model(3'd2, 32'hFFFFFFFB, 32'd0);
        run_op(3'd2, 32'hFFFFFFFB, 32'd0, lat);
        check({hi, lo} == {32'hFFFFFFFB, 32'hFFFFFFFF}, "R6", {hi, lo}, {32'hFFFFFFFB, 32'hFFFFFFFF});
        check(lat == 33, "R6", 64'(lat), 64'd33);
        run_op(3'd3, 32'h12345678, 32'd0, lat);
        check({hi, lo} == {32'h12345678, 32'hFFFFFFFF}, "R6", {hi, lo}, {32'h12345678, 32'hFFFFFFFF});
        check(lat == 33, "R6", 64'(lat), 64'd33);

        // R7: most negative by minus one
        run_op(3'd2, 32'h80000000, 32'hFFFFFFFF, lat);
        check({hi, lo} == {32'd0, 32'h80000000}, "R7", {hi, lo}, {32'd0, 32'h80000000});

        // R8: moves keep the other half
        run_op(3'd4, 32'h11112222, 32'd0, lat);
        check({hi, lo} == {32'h11112222, 32'h80000000}, "R8", {hi, lo}, {32'h11112222, 32'h80000000});
        run_op(3'd5, 32'h33334444, 32'd0, lat);
        check({hi, lo} == {32'h11112222, 32'h33334444}, "R8", {hi, lo}, {32'h11112222, 32'h33334444});

        // R10: start while busy is ignored
        @(negedge clk);
        start = 1'b1; op = 3'd3; opa = 32'd100; opb = 32'd7;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        repeat (3) begin @(negedge clk); lat++; end
        start = 1'b1; op = 3'd1; opa = 32'd3; opb = 32'd3;
        @(negedge clk);
        start = 1'b0; lat++;
        while (!done && lat < 100) begin @(negedge clk); lat++; end
        check({hi, lo} == {32'd2, 32'd14}, "R10", {hi, lo}, {32'd2, 32'd14});
        check(lat == 33, "R10", 64'(lat), 64'd33);
        begin
            bit quiet;
            quiet = 1'b1;
            repeat (4) begin
                @(negedge clk);
                if (busy || done) quiet = 1'b0;
            end
            check(quiet && {hi, lo} == {32'd2, 32'd14}, "R10 no follow-on", {hi, lo}, {32'd2, 32'd14});
        end

        // R11: reserved codes ignored
        for (int c = 6; c < 8; c++) begin
            bit quiet;
            quiet = 1'b1;
            @(negedge clk);
            start = 1'b1; op = 3'(c); opa = 32'hFFFFFFFF; opb = 32'hFFFFFFFF;
            @(negedge clk);
            start = 1'b0;
            repeat (3) begin
                if (busy || done) quiet = 1'b0;
                @(negedge clk);
            end
            check(quiet && {hi, lo} == {32'd2, 32'd14}, "R11", {hi, lo}, {32'd2, 32'd14});
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule